// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a 4-bit binary-coded decimal digit into the seven segment signals of a single display digit. A storage stage sits ahead of the decoder. While the hold control is low, this stage follows the input digit on every rising clock edge. While the hold control is high, it keeps the digit it last took, so the data bus can be shared or can change without disturbing the display.

Two active-low overrides act after the storage stage. The lamp-test control lights all seven segments so a display can be checked in one step. The blanking control darkens all seven segments and can be pulsed to set display brightness. Lamp test wins over blanking, and blanking wins over the normal decode. Neither override touches the stored digit, so the held value comes back on the display as soon as both controls are released. Codes 10 to 15 produce a dark digit, which gives a second way to blank the display through the data path.

Top module: `bcd_seg_latch_decoder`

## Requirements
- R1: A synchronous active-low reset clears the stored digit to 0. With both overrides inactive, the display then shows the glyph for 0 (seg_o = 7'h3F).
- R2: While hold_i is low, each rising clock edge stores digit_i. The display shows the new digit after that edge. digit_i[0] has weight 1 and digit_i[3] has weight 8.
- R3: While hold_i is high, the stored digit keeps the value taken at the last edge with hold_i low. Changes on digit_i have no effect on seg_o.
- R4: When blank_n is low and lamp_test_n is high, seg_o is 7'h00.
- R5: When lamp_test_n is low, seg_o is 7'h7F, whatever the values of blank_n, hold_i and the stored digit.
- R6: With both overrides inactive, stored codes 10 through 15 give seg_o = 7'h00.
- R7: seg_o bit 0 is segment a (top). Bits 1 to 6 are segments b (upper right), c (lower right), d (bottom), e (lower left), f (upper left) and g (middle). All segments are active high. For digits 0 to 9, seg_o is 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F and 67 (hex): the 6 has no top bar and the 9 has no bottom bar.
- R8: The overrides do not alter the stored digit. Once both are released, the display shows the held digit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_i | input | 1 | High keeps the stored digit; low lets it follow the input |
| blank_n | input | 1 | Active-low blanking control |
| lamp_test_n | input | 1 | Active-low control that lights all segments |
| digit_i | input | 4 | BCD digit input, bit 0 least significant |
| seg_o | output | 7 | Segment outputs a (bit 0) to g (bit 6), active high |

## Verification
The storage stage and the output overrides can act in the same clock cycle. The bench provokes this by loading a digit and then, in one cycle, raising the hold control, changing the data to a different code and applying any mix of lamp test and blanking. Every one of the 16 codes goes through all eight combinations of the three controls. Each result is judged at the segment outputs against the fixed priority applied to the digit that should be stored. Releasing both overrides afterwards shows whether the stored digit survived unchanged.

// File: rtl/bsd_pkg.sv
// Package: shared widths, types and named segment constants for the
// seven-segment latch decoder. Assumes bit 0 of a segment vector is
// segment a and bit 6 is segment g.
package bsd_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;
    localparam int MAX_BCD = 9;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    localparam seg_t SEG_ALL_ON  = {SEG_W{1'b1}};
    localparam seg_t SEG_ALL_OFF = {SEG_W{1'b0}};

    // Segment bit positions (a..g)
    localparam int SA = 0;
    localparam int SB = 1;
    localparam int SC = 2;
    localparam int SD = 3;
    localparam int SE = 4;
    localparam int SF = 5;
    localparam int SG = 6;

    // Build a segment vector from individual segment enables
    function automatic seg_t seg_mk(input logic a, input logic b, input logic c,
                                    input logic d, input logic e, input logic f,
                                    input logic g);
        seg_t s;
        s     = SEG_ALL_OFF;
        s[SA] = a;
        s[SB] = b;
        s[SC] = c;
        s[SD] = d;
        s[SE] = e;
        s[SF] = f;
        s[SG] = g;
        return s;
    endfunction
endpackage

// File: rtl/bsd_hold_stage.sv
// Module: storage stage for the incoming digit. Follows the input on each
// rising edge while hold_i is low and keeps its value while hold_i is high.
// Assumes a synchronous active-low reset that clears the stored digit to 0.
module bsd_hold_stage
    import bsd_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    // Capture the input digit when not holding; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (!hold_i) begin
            q_r <= d_i;
        end
    end

    assign q_o = q_r;

    // R3: a held digit does not move
    assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(q_r));

    // R2: an open stage takes the presented digit
    assert_follow_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (q_r == $past(d_i)));

    // R1: reset clears the stored digit
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (q_r == '0));
endmodule

// File: rtl/bsd_glyph_rom.sv
// Module: decodes a stored BCD digit to its seven-segment glyph. Codes
// above nine give a dark pattern. Assumes the a..g bit order of bsd_pkg.
module bsd_glyph_rom
    import bsd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  digit_t code_i,
    output seg_t   glyph_o
);
    // Map each decimal code to its segment pattern; other codes stay dark
    always_comb begin
        unique case (code_i)
            4'd0:    glyph_o = seg_mk(1, 1, 1, 1, 1, 1, 0);
            4'd1:    glyph_o = seg_mk(0, 1, 1, 0, 0, 0, 0);
            4'd2:    glyph_o = seg_mk(1, 1, 0, 1, 1, 0, 1);
            4'd3:    glyph_o = seg_mk(1, 1, 1, 1, 0, 0, 1);
            4'd4:    glyph_o = seg_mk(0, 1, 1, 0, 0, 1, 1);
            4'd5:    glyph_o = seg_mk(1, 0, 1, 1, 0, 1, 1);
            4'd6:    glyph_o = seg_mk(0, 0, 1, 1, 1, 1, 1);
            4'd7:    glyph_o = seg_mk(1, 1, 1, 0, 0, 0, 0);
            4'd8:    glyph_o = seg_mk(1, 1, 1, 1, 1, 1, 1);
            4'd9:    glyph_o = seg_mk(1, 1, 1, 0, 0, 1, 1);
            default: glyph_o = SEG_ALL_OFF;
        endcase
    end

    // R6: codes above nine never light a segment
    assert_dark_above_nine_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i > 4'(MAX_BCD)) |-> (glyph_o == SEG_ALL_OFF));

    // R7: every decimal glyph lights at least two segments
    assert_decimal_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i <= 4'(MAX_BCD)) |-> ($countones(glyph_o) >= 2));
endmodule

// File: rtl/bsd_override.sv
// Module: applies the display overrides after the decoder. Lamp test lights
// every segment and wins over blanking; blanking darkens every segment and
// wins over the decoded glyph. Both controls are active low and combinational.
module bsd_override
    import bsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lamp_test_n,
    input  logic blank_n,
    input  seg_t glyph_i,
    output seg_t seg_o
);
    // Fixed priority selection of the visible pattern
    always_comb begin
        if (!lamp_test_n) begin
            seg_o = SEG_ALL_ON;
        end else if (!blank_n) begin
            seg_o = SEG_ALL_OFF;
        end else begin
            seg_o = glyph_i;
        end
    end

    // R5: lamp test lights all segments
    assert_lamp_all_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_test_n |-> (seg_o == SEG_ALL_ON));

    // R4: blanking darkens all segments unless lamp test is active
    assert_blank_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_test_n && !blank_n) |-> (seg_o == SEG_ALL_OFF));

    // R8: with no override the glyph passes unchanged
    assert_glyph_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_test_n && blank_n) |-> (seg_o == glyph_i));
endmodule

// File: rtl/bcd_seg_latch_decoder.sv
// Module: top of the BCD seven-segment latch decoder. A storage stage holds
// the digit, a decoder forms the glyph, and an override stage applies lamp
// test and blanking. Assumes one digit per instance and active-high segments.
module bcd_seg_latch_decoder
    import bsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_i,
    input  logic               blank_n,
    input  logic               lamp_test_n,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [SEG_W-1:0]   seg_o
);
    digit_t stored_code;
    seg_t   glyph;

    bsd_hold_stage #(.W(DIGIT_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_i),
        .d_i    (digit_i),
        .q_o    (stored_code)
    );

    bsd_glyph_rom u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_i  (stored_code),
        .glyph_o (glyph)
    );

    bsd_override u_ovr (
        .clk         (clk),
        .rst_n       (rst_n),
        .lamp_test_n (lamp_test_n),
        .blank_n     (blank_n),
        .glyph_i     (glyph),
        .seg_o       (seg_o)
    );

    // R3: while held and free of overrides, the display does not change
    assert_display_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && lamp_test_n && blank_n && $past(hold_i)
         && $past(lamp_test_n) && $past(blank_n)) |-> $stable(seg_o));
endmodule

// File: tb/bcd_seg_latch_decoder_bench.sv
module bcd_seg_latch_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       hold_i;
    logic       blank_n;
    logic       lamp_test_n;
    logic [3:0] digit_i;
    logic [6:0] seg_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bcd_seg_latch_decoder u_bcd_seg_latch_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_i),
        .blank_n     (blank_n),
        .lamp_test_n (lamp_test_n),
        .digit_i     (digit_i),
        .seg_o       (seg_o)
    );

    // Reference glyphs from R7, bit 0 = a .. bit 6 = g
    function automatic logic [6:0] ref_glyph(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;
            4'd1: return 7'h06;
            4'd2: return 7'h5B;
            4'd3: return 7'h4F;
            4'd4: return 7'h66;
            4'd5: return 7'h6D;
            4'd6: return 7'h7C;
            4'd7: return 7'h07;
            4'd8: return 7'h7F;
            4'd9: return 7'h67;
            default: return 7'h00;   // R6
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        n_checks++;
        if (seg_o !== exp) begin
            n_fail++;
            $display("FAIL %s: seg_o=%h expected=%h", req, seg_o, exp);
        end
    endtask

    // Drive away from the edge, clock once, sample after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hold_i = 1'b0; blank_n = 1'b1; lamp_test_n = 1'b1;
        digit_i = 4'd7;
        step(); step();
        @(negedge clk);
        rst_n = 1'b0; hold_i = 1'b1;
        step();
        check("R1 reset", 7'h3F);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1 after reset, held", 7'h3F);
    endtask

    task automatic t_decode_all();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            hold_i = 1'b0; blank_n = 1'b1; lamp_test_n = 1'b1;
            digit_i = 4'(c);
            step();
            check(c > 9 ? "R6 code above nine" : "R7 R2 glyph", ref_glyph(4'(c)));
        end
    endtask

    // Load a code, then in one cycle: set hold, corrupt data, apply overrides
    task automatic t_control_sweep();
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < 8; m++) begin
                logic h, b, l;
                logic [3:0] held;
                logic [6:0] exp;
                h = m[0]; b = m[1]; l = m[2];
                @(negedge clk);
                hold_i = 1'b0; blank_n = 1'b1; lamp_test_n = 1'b1;
                digit_i = 4'(c);
                step();
                @(negedge clk);
                hold_i = h; blank_n = b; lamp_test_n = l;
                digit_i = h ? ~4'(c) : 4'(c);
                held = 4'(c);
                step();
                exp = !l ? 7'h7F : (!b ? 7'h00 : ref_glyph(held));
                check(!l ? "R5 lamp test" : (!b ? "R4 blank" : "R3 hold"), exp);
                @(negedge clk);
                blank_n = 1'b1; lamp_test_n = 1'b1;
                #1;
                check("R8 release restores", ref_glyph(held));
            end
        end
    endtask

    task automatic t_hold_long();
        @(negedge clk);
        hold_i = 1'b0; blank_n = 1'b1; lamp_test_n = 1'b1; digit_i = 4'd4;
        step();
        @(negedge clk);
        hold_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            digit_i = 4'(k + 1);
            step();
            check("R3 held across data changes", 7'h66);
            @(negedge clk);
        end
        hold_i = 1'b0; digit_i = 4'd2;
        step();
        check("R2 release follows input", 7'h5B);
    endtask

    initial begin
        t_reset();
        t_decode_all();
        t_control_sweep();
        t_hold_long();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule